// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 128 external interrupt lines and presents one interrupt request to a single processor. Each line has a configuration word and a destination word. The configuration word holds the following fields:
- a mask bit;
- a read-only activity flag;
- a 4-bit priority;
- a vector;
- a sense selector (level or edge);
- a polarity selector.

The controller raises `irq_out` when the best eligible pending line beats both the current task priority and every interrupt already in service.

Software works the block over a simple 32-bit word-addressed register bus. Reading the acknowledge register returns the winning line's vector and moves that line into service. If nothing is deliverable at that moment, the read returns a programmable spurious vector instead. Writing the end-of-interrupt register retires the highest-priority line in service.

In-service lines nest by priority. A self-clearing reset bit in the global configuration register returns every line to a masked default.

Lines are grouped in banks of sixteen. A line number is a bank index in its upper bits and a slot within the bank in its low four bits.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the block is in the following state:
  - Every line reads back configuration `0x80002000`: masked, active-high, edge sense, priority 0, vector 0.
  - Every destination word reads 0.
  - The task priority reads 0.
  - The spurious vector is `0xFF`.
  - `irq_out` is low.
- R2: Register map (9-bit word address):
  - global configuration at 0x000;
  - spurious vector at 0x001;
  - task priority at 0x002;
  - acknowledge at 0x003;
  - end-of-interrupt at 0x004;
  - line n configuration at 0x100+2n;
  - line n destination at 0x101+2n.

  A line address at or beyond NUM_SRC reads 0.
- R3: Configuration word layout:
  - bit 31 = mask;
  - bit 30 = activity (read-only);
  - bit 13 = polarity (1 active-high, 0 active-low);
  - bit 12 = sense (1 level, 0 edge);
  - bits 11:8 = priority;
  - bits 7:0 = vector.

  A level line is pending while its input sits at the active level.
- R4: An edge line latches pending on an inactive-to-active transition. It stays pending after the input returns, and an acknowledge clears it.
- R5: A line is eligible only when all three of the following hold:
  - it is pending;
  - it is unmasked;
  - bit 0 of its destination word is 1.
- R6: Among eligible lines the highest priority wins, and ties go to the lowest line number.
- R7: A candidate is delivered only when its priority is strictly greater than the task priority. A task priority of 15 therefore blocks everything.
- R8: A read of the acknowledge register behaves as follows:
  - If a candidate is deliverable, the read returns that candidate's vector and marks the line in service.
  - Otherwise it returns the spurious vector and changes nothing.
- R9: `irq_out` rises only when the candidate also beats the highest in-service priority. A write of any value to end-of-interrupt retires the highest-priority in-service line, with ties going to the lowest number.
- R10: A read of the end-of-interrupt register returns 0 and leaves all in-service state untouched.
- R11: The activity bit reads 1 while a line is pending or in service.
- R12: Writing 1 to bit 31 of the global configuration register has the following effects:
  - every line's configuration and destination return to the R1 values;
  - all pending and in-service state is cleared.

  The global register itself always reads 0.
- R13: Read data appears on `bus_rdata` one clock edge after the read is presented. `irq_out` follows the internal deliverable condition one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | External interrupt lines, synchronous to clk |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 9 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Each result has a fixed due time, and the bench samples every output on the falling edge right after that time:
- A level line's request is due one rising edge after the input reaches its active level.
- An edge line's request is due two rising edges after its transition, since the first edge only latches it. The bench confirms that `irq_out` is still low after the first edge and high after the second.
- After an acknowledge, `irq_out` falls one edge later than the read data appears.
- After an end-of-interrupt or configuration write, a re-enabled request is due on the following edge.

Acknowledge results are always read through the bus one edge after the read is presented.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int BUS_AW    = 9;
   localparam int PRIO_W    = 4;
   localparam int GRP_SIZE  = 16;
   localparam int MAX_SRC   = 128;
   localparam int MAX_VEC_W = 8;

   localparam int MASK_BIT  = 31;
   localparam int ACT_BIT   = 30;
   localparam int POL_BIT   = 13;
   localparam int SENSE_BIT = 12;
   localparam int PRIO_LSB  = 8;
   localparam int RST_BIT   = 31;

   localparam logic [BUS_AW-1:0] A_GCFG = 9'h000;
   localparam logic [BUS_AW-1:0] A_SPUR = 9'h001;
   localparam logic [BUS_AW-1:0] A_TASK = 9'h002;
   localparam logic [BUS_AW-1:0] A_ACK  = 9'h003;
   localparam logic [BUS_AW-1:0] A_EOI  = 9'h004;

   typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/pic_arbiter.sv
module pic_arbiter
   import pic_pkg::*;
#(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   input  prio_t            prio [N],
   output logic             valid,
   output logic [IDX_W-1:0] idx,
   output prio_t            best
);
   // strict compare keeps the lowest index on equal priority
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      best  = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (!valid || prio[i] > best)) begin
            valid = 1'b1;
            idx   = IDX_W'(i);
            best  = prio[i];
         end
      end
   end
endmodule

// File: rtl/pic_source.sv
module pic_source
   import pic_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             cfg_we,
   input  logic             dest_we,
   input  logic [31:0]      wdata,
   input  logic             irq,
   input  logic             ack_take,
   input  logic             eoi_take,
   output logic             eligible,
   output prio_t            prio,
   output logic [VEC_W-1:0] vec,
   output logic             in_svc,
   output logic [31:0]      cfg_word,
   output logic [31:0]      dest_word
);
   logic             mask_q, pol_q, sense_q, dest_q, prev_q, epend_q, isv_q;
   prio_t            prio_q;
   logic [VEC_W-1:0] vec_q;
   logic             asserted, pending;
   logic             unused_wdata;

   assign unused_wdata = ^wdata;
   assign asserted = pol_q ? irq : ~irq;
   assign pending  = sense_q ? asserted : epend_q;
   assign eligible = pending & ~isv_q & ~mask_q & dest_q;
   assign prio     = prio_q;
   assign vec      = vec_q;
   assign in_svc   = isv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= 1'b1;
         pol_q   <= 1'b1;
         sense_q <= 1'b0;
         prio_q  <= '0;
         vec_q   <= '0;
         dest_q  <= 1'b0;
         prev_q  <= 1'b0;
         epend_q <= 1'b0;
         isv_q   <= 1'b0;
      end else if (soft_rst) begin
         mask_q  <= 1'b1;
         pol_q   <= 1'b1;
         sense_q <= 1'b0;
         prio_q  <= '0;
         vec_q   <= '0;
         dest_q  <= 1'b0;
         prev_q  <= irq;
         epend_q <= 1'b0;
         isv_q   <= 1'b0;
      end else begin
         if (cfg_we) begin
            mask_q  <= wdata[MASK_BIT];
            pol_q   <= wdata[POL_BIT];
            sense_q <= wdata[SENSE_BIT];
            prio_q  <= wdata[PRIO_LSB +: PRIO_W];
            vec_q   <= wdata[VEC_W-1:0];
         end
         if (dest_we) dest_q <= wdata[0];
         prev_q  <= asserted;
         epend_q <= sense_q ? 1'b0 : ((epend_q & ~ack_take) | (asserted & ~prev_q));
         if (ack_take)      isv_q <= 1'b1;
         else if (eoi_take) isv_q <= 1'b0;
      end
   end

   always_comb begin
      cfg_word                     = '0;
      cfg_word[MASK_BIT]           = mask_q;
      cfg_word[ACT_BIT]            = pending | isv_q;
      cfg_word[POL_BIT]            = pol_q;
      cfg_word[SENSE_BIT]          = sense_q;
      cfg_word[PRIO_LSB +: PRIO_W] = prio_q;
      cfg_word[VEC_W-1:0]          = vec_q;
      dest_word                    = {31'b0, dest_q};
   end

   // R8
   ack_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take |-> eligible);
   // R8
   ack_enters_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take && !soft_rst |=> isv_q);
   // R9
   eoi_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_take |-> isv_q);
   // R12
   soft_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> mask_q && !isv_q && !epend_q);
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
   import pic_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int VEC_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [BUS_AW-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq_out
);
   localparam int IDX_W  = $clog2(NUM_SRC);
   localparam int GROUPS = NUM_SRC / GRP_SIZE;

   if (NUM_SRC % GRP_SIZE != 0 || NUM_SRC < GRP_SIZE || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("pic_ctrl: NUM_SRC must be a multiple of 16 in 16..128");
   end
   if (VEC_W < 1 || VEC_W > MAX_VEC_W) begin : g_bad_vec
      $error("pic_ctrl: VEC_W must be 1..8");
   end

   logic               wr_en, rd_en, src_hit, soft_rst;
   logic [IDX_W-1:0]   src_sel;
   logic [NUM_SRC-1:0] elig, isv, cfg_we, dest_we, ack_take, eoi_take;
   prio_t              src_prio [NUM_SRC];
   logic [VEC_W-1:0]   src_vec  [NUM_SRC];
   logic [31:0]        cfg_rd   [NUM_SRC];
   logic [31:0]        dest_rd  [NUM_SRC];

   logic               cand_valid, isv_valid, deliverable, ack_hit, eoi_hit;
   logic [IDX_W-1:0]   cand_idx, isv_idx;
   prio_t              cand_prio, isv_prio, task_q;
   logic [VEC_W-1:0]   spur_q;
   logic [31:0]        rdata_q;
   logic               irq_q;

   assign wr_en    = bus_sel & bus_wr;
   assign rd_en    = bus_sel & ~bus_wr;
   assign src_hit  = bus_addr[BUS_AW-1] && ({1'b0, bus_addr[BUS_AW-2:1]} < 8'(NUM_SRC));
   assign src_sel  = bus_addr[IDX_W:1];
   assign soft_rst = wr_en && bus_addr == A_GCFG && bus_wdata[RST_BIT];

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      for (genvar i = 0; i < GRP_SIZE; i++) begin : g_slot
         localparam int N = g * GRP_SIZE + i;
         assign cfg_we[N]  = wr_en & src_hit & ~bus_addr[0] & (src_sel == IDX_W'(N));
         assign dest_we[N] = wr_en & src_hit &  bus_addr[0] & (src_sel == IDX_W'(N));
         pic_source #(.VEC_W(VEC_W)) u_src (
            .clk       (clk),
            .rst_n     (rst_n),
            .soft_rst  (soft_rst),
            .cfg_we    (cfg_we[N]),
            .dest_we   (dest_we[N]),
            .wdata     (bus_wdata),
            .irq       (irq_in[N]),
            .ack_take  (ack_take[N]),
            .eoi_take  (eoi_take[N]),
            .eligible  (elig[N]),
            .prio      (src_prio[N]),
            .vec       (src_vec[N]),
            .in_svc    (isv[N]),
            .cfg_word  (cfg_rd[N]),
            .dest_word (dest_rd[N])
         );
      end
   end

   pic_arbiter #(.N(NUM_SRC), .IDX_W(IDX_W)) u_cand_arb (
      .req (elig), .prio (src_prio), .valid (cand_valid), .idx (cand_idx), .best (cand_prio)
   );
   pic_arbiter #(.N(NUM_SRC), .IDX_W(IDX_W)) u_isv_arb (
      .req (isv), .prio (src_prio), .valid (isv_valid), .idx (isv_idx), .best (isv_prio)
   );

   assign deliverable = cand_valid && cand_prio > task_q && (!isv_valid || cand_prio > isv_prio);
   assign ack_hit     = rd_en && bus_addr == A_ACK && deliverable;
   assign eoi_hit     = wr_en && bus_addr == A_EOI && isv_valid;
   assign ack_take    = ack_hit ? (NUM_SRC'(1) << cand_idx) : '0;
   assign eoi_take    = eoi_hit ? (NUM_SRC'(1) << isv_idx)  : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         task_q  <= '0;
         spur_q  <= '1;
         rdata_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= deliverable;
         if (wr_en && bus_addr == A_TASK) task_q <= bus_wdata[PRIO_W-1:0];
         if (wr_en && bus_addr == A_SPUR) spur_q <= bus_wdata[VEC_W-1:0];
         if (rd_en) begin
            if (src_hit)
               rdata_q <= bus_addr[0] ? dest_rd[src_sel] : cfg_rd[src_sel];
            else begin
               case (bus_addr)
                  A_SPUR:  rdata_q <= 32'(spur_q);
                  A_TASK:  rdata_q <= 32'(task_q);
                  A_ACK:   rdata_q <= deliverable ? 32'(src_vec[cand_idx]) : 32'(spur_q);
                  default: rdata_q <= '0;
               endcase
            end
         end
      end
   end

   assign bus_rdata = rdata_q;
   assign irq_out   = irq_q;

   // R9
   ack_nests_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit |=> isv_valid && isv_prio >= $past(cand_prio));
   // R7
   task_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      task_q == '1 |=> !irq_out);
endmodule

// File: tb/tb_pic_ctrl.sv
`timescale 1ns/1ps
module tb_pic_ctrl;
   localparam int NS = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] irq_in = '0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [8:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_out;
   int            n_cmp = 0, n_err = 0;
   bit            done = 1'b0;

   always #2.5 clk = ~clk;

   pic_ctrl #(.NUM_SRC(NS), .VEC_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   localparam logic [8:0] GCFG = 9'h000, SPUR = 9'h001, TPRI = 9'h002, ACK = 9'h003, EOI = 9'h004;

   function automatic logic [8:0] cfg_a(input int n);
      return 9'(9'h100 + 2 * n);
   endfunction
   function automatic logic [8:0] dst_a(input int n);
      return 9'(9'h101 + 2 * n);
   endfunction
   function automatic logic [31:0] mk(input bit m, input bit s, input bit p,
                                      input logic [3:0] pr, input logic [7:0] v);
      return {m, 1'b0, 16'b0, p, s, pr, v};
   endfunction
   localparam logic [31:0] ACT = 32'h4000_0000;

   task automatic tick();
      @(negedge clk);
   endtask
   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask
   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask
   task automatic chk_rd(input string req, input logic [8:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask
   task automatic setup(input int n, input logic [31:0] cfg, input bit dst);
      wr(dst_a(n), {31'b0, dst});
      wr(cfg_a(n), cfg);
   endtask

   task automatic t_reset();
      chk("R1 irq_out", {31'b0, irq_out}, 0);
      chk_rd("R1 cfg0", cfg_a(0), 32'h8000_2000);
      chk_rd("R1 cfg31", cfg_a(31), 32'h8000_2000);
      chk_rd("R1 dest0", dst_a(0), 0);
      chk_rd("R1 task", TPRI, 0);
      chk_rd("R1 spurious ack", ACK, 32'hFF);
   endtask

   task automatic t_level();
      setup(3, mk(0, 1, 1, 5, 8'h23), 1);
      irq_in[3] = 1'b1; tick();
      chk("R3 R13 level irq_out", {31'b0, irq_out}, 1);
      chk_rd("R11 level activity", cfg_a(3), ACT | mk(0, 1, 1, 5, 8'h23));
      chk_rd("R8 ack vector", ACK, 32'h23);
      tick();
      chk("R13 irq_out falls after ack", {31'b0, irq_out}, 0);
      chk_rd("R9 in service blocks same line", ACK, 32'hFF);
      wr(EOI, 0); tick();
      chk("R3 level re-sampled after eoi", {31'b0, irq_out}, 1);
      chk_rd("R8 ack again", ACK, 32'h23);
      irq_in[3] = 1'b0;
      wr(EOI, 0); tick();
      chk("R3 level dropped", {31'b0, irq_out}, 0);
      chk_rd("R11 activity cleared", cfg_a(3), mk(0, 1, 1, 5, 8'h23));
      wr(cfg_a(3), mk(1, 1, 1, 5, 8'h23));
   endtask

   task automatic t_polarity();
      setup(4, mk(0, 1, 0, 6, 8'h24), 1); tick();
      chk("R3 active-low asserted", {31'b0, irq_out}, 1);
      irq_in[4] = 1'b1; tick();
      chk("R3 active-low released", {31'b0, irq_out}, 0);
      wr(cfg_a(4), mk(1, 1, 1, 6, 8'h24));
   endtask

   task automatic t_edge();
      setup(5, mk(0, 0, 1, 7, 8'h45), 1);
      irq_in[5] = 1'b1; tick();
      chk("R4 edge latch stage", {31'b0, irq_out}, 0);
      irq_in[5] = 1'b0; tick();
      chk("R4 edge irq after two edges", {31'b0, irq_out}, 1);
      chk_rd("R11 edge activity", cfg_a(5), ACT | mk(0, 0, 1, 7, 8'h45));
      chk_rd("R4 edge ack", ACK, 32'h45);
      wr(EOI, 0); tick();
      chk("R4 edge consumed", {31'b0, irq_out}, 0);
      chk_rd("R4 no re-delivery", ACK, 32'hFF);
      wr(cfg_a(5), mk(1, 0, 1, 7, 8'h45));
   endtask

   task automatic t_arb();
      setup(2,  mk(0, 1, 1, 4,  8'h12), 1);
      setup(9,  mk(0, 1, 1, 9,  8'h19), 1);
      setup(10, mk(0, 1, 1, 9,  8'h1A), 1);
      setup(12, mk(0, 1, 1, 12, 8'h1C), 1);
      irq_in[2] = 1'b1; irq_in[9] = 1'b1; irq_in[10] = 1'b1;
      tick(); tick();
      chk_rd("R6 highest prio tie lowest", ACK, 32'h19);
      tick();
      chk("R9 equal prio held off", {31'b0, irq_out}, 0);
      chk_rd("R9 equal prio spurious", ACK, 32'hFF);
      irq_in[9] = 1'b0;
      wr(EOI, 0);
      chk_rd("R6 next of tie", ACK, 32'h1A);
      irq_in[12] = 1'b1; tick(); tick();
      chk("R9 higher nests", {31'b0, irq_out}, 1);
      chk_rd("R9 nested ack", ACK, 32'h1C);
      irq_in[12] = 1'b0;
      wr(EOI, 0);
      chk_rd("R9 eoi retired highest", cfg_a(12), mk(0, 1, 1, 12, 8'h1C));
      chk_rd("R9 lower still in service", cfg_a(10), ACT | mk(0, 1, 1, 9, 8'h1A));
      chk_rd("R9 lower prio blocked", ACK, 32'hFF);
      irq_in[10] = 1'b0;
      wr(EOI, 0);
      chk_rd("R6 last line", ACK, 32'h12);
      irq_in[2] = 1'b0;
      wr(EOI, 0);
      wr(cfg_a(2), mk(1, 1, 1, 4, 8'h12));
      wr(cfg_a(9), mk(1, 1, 1, 9, 8'h19));
      wr(cfg_a(10), mk(1, 1, 1, 9, 8'h1A));
      wr(cfg_a(12), mk(1, 1, 1, 12, 8'h1C));
   endtask

   task automatic t_task();
      wr(TPRI, 32'hF);
      setup(6, mk(0, 1, 1, 4, 8'h26), 1);
      irq_in[6] = 1'b1; tick(); tick();
      chk("R7 task 15 blocks", {31'b0, irq_out}, 0);
      chk_rd("R7 task 15 spurious", ACK, 32'hFF);
      wr(TPRI, 32'h4); tick();
      chk("R7 equal prio blocked", {31'b0, irq_out}, 0);
      chk_rd("R7 equal prio spurious", ACK, 32'hFF);
      wr(TPRI, 32'h3); tick();
      chk("R7 greater delivered", {31'b0, irq_out}, 1);
      chk_rd("R7 ack", ACK, 32'h26);
      irq_in[6] = 1'b0;
      wr(EOI, 0);
      wr(TPRI, 32'h0);
      wr(cfg_a(6), mk(1, 1, 1, 4, 8'h26));
   endtask

   task automatic t_elig();
      setup(7, mk(0, 1, 1, 8, 8'h27), 0);
      irq_in[7] = 1'b1; tick(); tick();
      chk("R5 dest clear blocks", {31'b0, irq_out}, 0);
      chk_rd("R5 dest clear spurious", ACK, 32'hFF);
      chk_rd("R11 pending shows", cfg_a(7), ACT | mk(0, 1, 1, 8, 8'h27));
      wr(dst_a(7), 1); tick();
      chk("R5 dest set delivers", {31'b0, irq_out}, 1);
      wr(cfg_a(7), mk(1, 1, 1, 8, 8'h27)); tick();
      chk("R5 mask blocks", {31'b0, irq_out}, 0);
      chk_rd("R5 mask spurious", ACK, 32'hFF);
      irq_in[7] = 1'b0;
   endtask

   task automatic t_eoi_read();
      setup(8, mk(0, 0, 1, 3, 8'h28), 1);
      irq_in[8] = 1'b1; tick(); irq_in[8] = 1'b0; tick();
      chk_rd("R10 ack", ACK, 32'h28);
      chk_rd("R10 eoi reads zero", EOI, 0);
      chk_rd("R10 read keeps service", cfg_a(8), ACT | mk(0, 0, 1, 3, 8'h28));
      wr(EOI, 32'hDEAD);
      chk_rd("R9 any value retires", cfg_a(8), mk(0, 0, 1, 3, 8'h28));
      wr(cfg_a(8), mk(1, 0, 1, 3, 8'h28));
   endtask

   task automatic t_group();
      wr(cfg_a(17), mk(1, 1, 1, 2, 8'h71));
      wr(dst_a(17), 1);
      chk_rd("R2 bank1 slot1 cfg", cfg_a(17), mk(1, 1, 1, 2, 8'h71));
      chk_rd("R2 bank1 slot1 dest", dst_a(17), 1);
      chk_rd("R2 bank0 slot1 untouched", cfg_a(1), 32'h8000_2000);
      chk_rd("R2 out of range", cfg_a(40), 0);
   endtask

   task automatic t_spur();
      wr(SPUR, 32'h5A);
      chk_rd("R2 spurious reg", SPUR, 32'h5A);
      chk_rd("R8 programmed spurious", ACK, 32'h5A);
   endtask

   task automatic t_softrst();
      setup(11, mk(0, 1, 1, 10, 8'h2B), 1);
      irq_in[11] = 1'b1; tick(); tick();
      chk("R12 pre-reset delivered", {31'b0, irq_out}, 1);
      wr(GCFG, 32'h8000_0000); tick();
      chk("R12 irq_out dropped", {31'b0, irq_out}, 0);
      chk_rd("R12 global self-clears", GCFG, 0);
      chk_rd("R12 cfg default", cfg_a(11), 32'h8000_2000);
      chk_rd("R12 dest default", dst_a(11), 0);
      chk_rd("R12 cfg17 default", cfg_a(17), 32'h8000_2000);
      irq_in[11] = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: got hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_level();
      t_polarity();
      t_edge();
      t_arb();
      t_task();
      t_elig();
      t_eoi_read();
      t_group();
      t_spur();
      t_softrst();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end
endmodule